// File: doc/BRIEF.md
# Serial Clock-Calendar Slave

This block is the device side of a three-wire serial link to a clock-calendar. The host raises a chip-enable, toggles a serial clock and shifts bits in on a data-in line; the block answers on a separate data-out line. Each transaction is a 16-bit frame. The first byte is a command. The command value alone decides whether the second byte flows toward the block, where it is stored, or away from it, where a byte from scratch RAM, the time-of-day counters, the status register or the control register is shifted out.

Behind the serial engine sit a 32-byte scratch RAM, a status register, a read-only control register and a packed-BCD calendar. The calendar advances once every `TICK_DIV` system clocks. A power-event interrupt output is high after reset. Software lowers it by writing a clear key to the status-write command. The serial lines are sampled in the system clock domain. A falling edge of the serial clock is seen when the registered clock level is high and the current level is low.

Top module: `clkcal_serial_top`

## Requirements
- R1: After reset, `sdo_o` is 0, `pwr_irq_o` is 1, the status byte reads 0x90, the control byte reads `CTRL_INIT` (0x00 by default) and every RAM byte reads 0x00.
- R2: While `ce_i` is high, each falling edge of `sclk_i` advances the frame by one bit. Edges 1 to 8 shift the command in on `sdi_i`, most significant bit first. Edges 9 to 16 carry the data byte, most significant bit first.
- R3: Commands 0x80 to 0x9F and 0xB1 are writes; all other commands are reads. A write to 0x80+n stores the shifted-in data byte into RAM byte n on the 16th edge. A read of command n, where n is 0x00 to 0x1F, returns RAM byte n.
- R4: In a read frame, after falling edge 9+k (k = 0 to 7), `sdo_o` shows bit 7-k of the return byte. `sdo_o` is 0 whenever `ce_i` is low.
- R5: Reads return packed-BCD time fields: 0x20 seconds, 0x21 minutes, 0x22 hours, 0x24 day of month, 0x25 month (01 to 12) and 0x26 two-digit year. Reads of 0x23 and 0x27 to 0x2F return 0. The return byte is captured on the 8th edge.
- R6: Read 0x30 returns status and read 0x31 returns control. A write with command 0xB1 and data bit 2 set clears status bits 4 and 3 and drives `pwr_irq_o` low. With data bit 2 clear, the write changes nothing.
- R7: Lowering `ce_i` clears the bit counter, the command and the data shift registers. A frame aborted before its 16th edge writes nothing.
- R8: Falling edges after the 16th in the same enable window are ignored until `ce_i` goes low.
- R9: The seconds field advances by one every `TICK_DIV` clocks. Seconds and minutes roll 59 to 00 with a carry to the next field, and hours roll 23 to 00 with a carry to the day.
- R10: The day rolls back to 01 after the month's last day: 28 for month 02, 30 for months 04, 06, 09 and 11, 31 otherwise. Month 12 rolls to 01 and increments the year, and year 99 rolls to 00.
- R11: Reads of unassigned commands (0x32 to 0x7F, and 0xA0 to 0xFF except 0xB1) return 0x00.
- R12: Serial clock edges while `ce_i` is low change no state and do not drive `sdo_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Chip-enable, active high; a low level ends or aborts a frame |
| sclk_i | input | 1 | Serial clock; falling edges are the bit strobes |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host during read frames |
| pwr_irq_o | output | 1 | Power-event interrupt, high until cleared |

## Verification
A calendar tick can land in the same system cycle in which the eighth command edge captures a seconds read. A torn or half-updated byte would be wrong. The bench provokes this by issuing about forty back-to-back seconds reads across a tick boundary. Every byte returned must equal either the previous reading or its BCD successor, and at least one change must be seen. The rollover cascade, from 23:59:50 on 31 December of year 99 to midnight on 1 January of year 00, is judged at a sampling time chosen well away from any tick.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;

    localparam int BYTE_W = 8;
    localparam int FRAME_LEN = 2 * BYTE_W;

    localparam logic [7:0] CMD_RAM_WR_LO = 8'h80;
    localparam logic [7:0] CMD_RAM_WR_HI = 8'h9F;
    localparam logic [7:0] CMD_STAT_WR   = 8'hB1;
    localparam logic [7:0] CMD_STAT_RD   = 8'h30;
    localparam logic [7:0] CMD_CTRL_RD   = 8'h31;
    localparam logic [3:0] CMD_TIME_PAGE = 4'h2;

    localparam int         STAT_CLR_KEY_BIT = 2;
    localparam logic [7:0] STAT_PWR_MASK    = 8'h18;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
    } bcd_time_t;

    typedef struct packed {
        logic       stb;
        logic [7:0] cmd;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic cmd_is_write(input logic [7:0] c);
        return ((c >= CMD_RAM_WR_LO) && (c <= CMD_RAM_WR_HI)) || (c == CMD_STAT_WR);
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] m);
        case (m)
            8'h02:                      return 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/clkcal_shift.sv
module clkcal_shift
    import clkcal_pkg::*;
#(
    parameter int PH_W = $clog2(FRAME_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_i,
    input  logic            sclk_i,
    input  logic            sdi_i,
    input  logic [7:0]      rd_byte_i,
    output logic [7:0]      cmd_next_o,
    output logic            sdo_o,
    output wr_req_t         wr_o,
    output logic [PH_W-1:0] phase_o
);
    localparam logic [PH_W-1:0] PH_CMD_LAST = PH_W'(BYTE_W - 1);
    localparam logic [PH_W-1:0] PH_DATA     = PH_W'(BYTE_W);
    localparam logic [PH_W-1:0] PH_LAST     = PH_W'(FRAME_LEN - 1);
    localparam logic [PH_W-1:0] PH_END      = PH_W'(FRAME_LEN);

    logic            sclk_q;
    logic [PH_W-1:0] phase_q;
    logic [7:0]      cmd_q;
    logic [7:0]      data_q;
    logic [7:0]      ret_q;
    logic            sdo_q;
    logic            fall;
    logic [7:0]      data_next;
    logic [2:0]      bit_idx;

    assign fall       = ce_i && sclk_q && !sclk_i;
    assign cmd_next_o = {cmd_q[6:0], sdi_i};
    assign data_next  = {data_q[6:0], sdi_i};
    assign bit_idx    = 3'(PH_LAST - phase_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            phase_q <= '0;
            cmd_q   <= '0;
            data_q  <= '0;
            ret_q   <= '0;
            sdo_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            if (!ce_i) begin
                phase_q <= '0;
                cmd_q   <= '0;
                data_q  <= '0;
                ret_q   <= '0;
                sdo_q   <= 1'b0;
            end else if (fall && (phase_q < PH_END)) begin
                phase_q <= phase_q + 1'b1;
                if (phase_q < PH_DATA) begin
                    cmd_q <= cmd_next_o;
                    if (phase_q == PH_CMD_LAST) begin
                        ret_q <= rd_byte_i;
                    end
                end else if (cmd_is_write(cmd_q)) begin
                    data_q <= data_next;
                end else begin
                    sdo_q <= ret_q[bit_idx];
                end
            end
        end
    end

    assign wr_o.stb  = fall && (phase_q == PH_LAST) && cmd_is_write(cmd_q);
    assign wr_o.cmd  = cmd_q;
    assign wr_o.data = data_next;
    assign sdo_o     = sdo_q;
    assign phase_o   = phase_q;

endmodule

// File: rtl/clkcal_time.sv
module clkcal_time
    import clkcal_pkg::*;
#(
    parameter int          TICK_DIV  = 100_000_000,
    parameter logic [47:0] INIT_TIME = 48'h00_01_01_00_00_00
) (
    input  logic      clk,
    input  logic      rst,
    output bcd_time_t now_o
);
    localparam int            CW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] pre_q;
    logic          tick;
    bcd_time_t     cur_q;
    bcd_time_t     nxt;

    assign tick = (pre_q == DIV_LAST);

    always_comb begin
        nxt = cur_q;
        if (cur_q.second != 8'h59) begin
            nxt.second = bcd_inc(cur_q.second);
        end else begin
            nxt.second = 8'h00;
            if (cur_q.minute != 8'h59) begin
                nxt.minute = bcd_inc(cur_q.minute);
            end else begin
                nxt.minute = 8'h00;
                if (cur_q.hour != 8'h23) begin
                    nxt.hour = bcd_inc(cur_q.hour);
                end else begin
                    nxt.hour = 8'h00;
                    if (cur_q.day != month_last_day(cur_q.month)) begin
                        nxt.day = bcd_inc(cur_q.day);
                    end else begin
                        nxt.day = 8'h01;
                        if (cur_q.month != 8'h12) begin
                            nxt.month = bcd_inc(cur_q.month);
                        end else begin
                            nxt.month = 8'h01;
                            nxt.year  = (cur_q.year == 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cur_q <= INIT_TIME;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                cur_q <= nxt;
            end
        end
    end

    assign now_o = cur_q;

endmodule

// File: rtl/clkcal_regs.sv
module clkcal_regs
    import clkcal_pkg::*;
#(
    parameter int         RAM_DEPTH   = 32,
    parameter logic [7:0] STATUS_INIT = 8'h90,
    parameter logic [7:0] CTRL_INIT   = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr_i,
    input  logic [7:0] rd_cmd_i,
    input  bcd_time_t  now_i,
    output logic [7:0] rd_byte_o,
    output logic       pwr_irq_o
);
    localparam int         AW      = $clog2(RAM_DEPTH);
    localparam logic [7:0] RAM_TOP = 8'(RAM_DEPTH);
    localparam logic [7:0] WR_TOP  = CMD_RAM_WR_LO + 8'(RAM_DEPTH - 1);

    logic [7:0] ram_q [RAM_DEPTH];
    logic [7:0] status_q;
    logic       irq_q;
    logic       ram_hit;
    logic       clr_hit;

    assign ram_hit = wr_i.stb && (wr_i.cmd >= CMD_RAM_WR_LO) && (wr_i.cmd <= WR_TOP);
    assign clr_hit = wr_i.stb && (wr_i.cmd == CMD_STAT_WR) && wr_i.data[STAT_CLR_KEY_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_DEPTH; i++) begin
                ram_q[i] <= '0;
            end
            status_q <= STATUS_INIT;
            irq_q    <= 1'b1;
        end else begin
            if (ram_hit) begin
                ram_q[wr_i.cmd[AW-1:0]] <= wr_i.data;
            end
            if (clr_hit) begin
                status_q <= status_q & ~STAT_PWR_MASK;
                irq_q    <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_byte_o = '0;
        if (rd_cmd_i < RAM_TOP) begin
            rd_byte_o = ram_q[rd_cmd_i[AW-1:0]];
        end else if (rd_cmd_i[7:4] == CMD_TIME_PAGE) begin
            case (rd_cmd_i[3:0])
                4'h0:    rd_byte_o = now_i.second;
                4'h1:    rd_byte_o = now_i.minute;
                4'h2:    rd_byte_o = now_i.hour;
                4'h4:    rd_byte_o = now_i.day;
                4'h5:    rd_byte_o = now_i.month;
                4'h6:    rd_byte_o = now_i.year;
                default: rd_byte_o = '0;
            endcase
        end else if (rd_cmd_i == CMD_STAT_RD) begin
            rd_byte_o = status_q;
        end else if (rd_cmd_i == CMD_CTRL_RD) begin
            rd_byte_o = CTRL_INIT;
        end
    end

    assign pwr_irq_o = irq_q;

endmodule

// File: rtl/clkcal_serial_top.sv
module clkcal_serial_top
    import clkcal_pkg::*;
#(
    parameter int          TICK_DIV    = 100_000_000,
    parameter int          RAM_DEPTH   = 32,
    parameter logic [7:0]  STATUS_INIT = 8'h90,
    parameter logic [7:0]  CTRL_INIT   = 8'h00,
    parameter logic [47:0] INIT_TIME   = 48'h00_01_01_00_00_00
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic pwr_irq_o
);
    localparam int PH_W = $clog2(FRAME_LEN + 1);

    logic [7:0]      cmd_next_w;
    logic [7:0]      rd_byte_w;
    wr_req_t         wr_w;
    logic [PH_W-1:0] phase_w;
    bcd_time_t       now_w;
    logic [7:0]      sec_w;
    logic            clr_key_w;

    assign sec_w     = now_w.second;
    assign clr_key_w = wr_w.data[STAT_CLR_KEY_BIT];

    clkcal_shift #(.PH_W(PH_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ce_i       (ce_i),
        .sclk_i     (sclk_i),
        .sdi_i      (sdi_i),
        .rd_byte_i  (rd_byte_w),
        .cmd_next_o (cmd_next_w),
        .sdo_o      (sdo_o),
        .wr_o       (wr_w),
        .phase_o    (phase_w)
    );

    clkcal_regs #(
        .RAM_DEPTH   (RAM_DEPTH),
        .STATUS_INIT (STATUS_INIT),
        .CTRL_INIT   (CTRL_INIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr_w),
        .rd_cmd_i  (cmd_next_w),
        .now_i     (now_w),
        .rd_byte_o (rd_byte_w),
        .pwr_irq_o (pwr_irq_o)
    );

    clkcal_time #(
        .TICK_DIV  (TICK_DIV),
        .INIT_TIME (INIT_TIME)
    ) u_time (
        .clk   (clk),
        .rst   (rst),
        .now_o (now_w)
    );

endmodule

// File: rtl/clkcal_chk.sv
module clkcal_chk
    import clkcal_pkg::*;
#(
    parameter int PH_W = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            ce_i,
    input logic            sdo_o,
    input logic            pwr_irq_o,
    input logic [PH_W-1:0] phase,
    input logic            wr_stb,
    input logic [7:0]      wr_cmd,
    input logic            clr_key,
    input logic [7:0]      sec
);
    localparam logic [PH_W-1:0] PH_END = PH_W'(FRAME_LEN);

    a_r8_phase_capped: assert property (@(posedge clk) disable iff (rst)
        phase <= PH_END);

    a_r8_hold_after_end: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_END && ce_i) |=> (phase == PH_END));

    a_r7_ce_low_clears: assert property (@(posedge clk) disable iff (rst)
        !ce_i |=> (phase == '0));

    a_r4_sdo_idle_low: assert property (@(posedge clk) disable iff (rst)
        !ce_i |=> !sdo_o);

    a_r3_write_on_last_edge: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (phase == PH_END));

    a_r3_write_cmd_class: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> cmd_is_write(wr_cmd));

    a_r6_irq_never_rises: assert property (@(posedge clk) disable iff (rst)
        !$rose(pwr_irq_o));

    a_r6_irq_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_irq_o) |-> $past(wr_stb && (wr_cmd == CMD_STAT_WR) && clr_key));

    a_r9_sec_is_bcd: assert property (@(posedge clk) disable iff (rst)
        (sec[3:0] <= 4'd9) && (sec[7:4] <= 4'd5));

endmodule

bind clkcal_serial_top clkcal_chk #(.PH_W(PH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_i      (ce_i),
    .sdo_o     (sdo_o),
    .pwr_irq_o (pwr_irq_o),
    .phase     (phase_w),
    .wr_stb    (wr_w.stb),
    .wr_cmd    (wr_w.cmd),
    .clr_key   (clr_key_w),
    .sec       (sec_w)
);

// File: tb/clkcal_serial_top_tb_top.sv
module clkcal_serial_top_tb_top;

    localparam int TICK = 2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic pwr_irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    clkcal_serial_top #(
        .TICK_DIV  (TICK),
        .INIT_TIME (48'h99_12_31_23_59_50)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ce_i      (ce),
        .sclk_i    (sclk),
        .sdi_i     (sdi),
        .sdo_o     (sdo),
        .pwr_irq_o (pwr_irq)
    );

    // {is_write, cmd, write data or expected read byte}
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 8'h80, 8'hA5},
        {1'b1, 8'h9F, 8'h3C},
        {1'b1, 8'h85, 8'hFF},
        {1'b0, 8'h00, 8'hA5},
        {1'b0, 8'h1F, 8'h3C},
        {1'b0, 8'h05, 8'hFF},
        {1'b0, 8'h01, 8'h00},
        {1'b0, 8'h23, 8'h00},
        {1'b0, 8'h2F, 8'h00},
        {1'b0, 8'h31, 8'h00},
        {1'b0, 8'h40, 8'h00},
        {1'b0, 8'hA0, 8'h00},
        {1'b0, 8'hFF, 8'h00},
        {1'b0, 8'h30, 8'h90}
    };

    function automatic string req_of(input logic [7:0] c);
        if (c < 8'h20)                   return "R3";
        if (c[7:4] == 4'h2)              return "R5";
        if (c == 8'h30 || c == 8'h31)    return "R6";
        return "R11";
    endfunction

    function automatic logic [7:0] tb_bcd_next(input logic [7:0] v);
        if (v == 8'h59)      return 8'h00;
        if (v[3:0] == 4'd9)  return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic frame(input logic [23:0] pat, input int nbits, output logic [7:0] rd);
        rd = '0;
        @(negedge clk); ce = 1'b1;
        @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1; sdi = pat[23-i];
            @(negedge clk); @(negedge clk);
            sclk = 1'b0;
            @(negedge clk); @(negedge clk);
            if (i >= 8 && i < 16) rd[15-i] = sdo;
        end
        ce = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, output logic [7:0] rd);
        frame({cmd, wd, 8'h00}, 16, rd);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] prev;
        bit changed;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "sdo after reset", {7'd0, sdo}, 8'h00);
        chk("R1", "irq after reset", {7'd0, pwr_irq}, 8'h01);
        xfer(8'h30, 8'h00, rd); chk("R1", "status reset", rd, 8'h90);
        xfer(8'h31, 8'h00, rd); chk("R1", "control reset", rd, 8'h00);
        xfer(8'h0A, 8'h00, rd); chk("R1", "ram reset", rd, 8'h00);

        // R5 time fields before the first tick
        xfer(8'h20, 8'h00, rd); chk("R5", "seconds", rd, 8'h50);
        xfer(8'h21, 8'h00, rd); chk("R5", "minutes", rd, 8'h59);
        xfer(8'h22, 8'h00, rd); chk("R5", "hours", rd, 8'h23);
        xfer(8'h24, 8'h00, rd); chk("R5", "day", rd, 8'h31);
        xfer(8'h25, 8'h00, rd); chk("R5", "month", rd, 8'h12);
        xfer(8'h26, 8'h00, rd); chk("R5", "year", rd, 8'h99);

        // R2 R3 R4 R5 R6 R11 vector walk
        for (int v = 0; v < NV; v++) begin
            xfer(VEC[v][15:8], VEC[v][7:0], rd);
            if (!VEC[v][16]) chk(req_of(VEC[v][15:8]), "vector read", rd, VEC[v][7:0]);
        end

        // R7 aborted write leaves RAM untouched
        frame({8'h82, 8'h77, 8'h00}, 12, rd);
        xfer(8'h02, 8'h00, rd); chk("R7", "abort no write", rd, 8'h00);

        // R8 edges past 16 ignored
        frame({8'h82, 8'h11, 8'hEE}, 24, rd);
        xfer(8'h02, 8'h00, rd); chk("R8", "extra edges ignored", rd, 8'h11);
        frame({8'h02, 8'h00, 8'hFF}, 24, rd); chk("R8", "read with extra edges", rd, 8'h11);

        // R12 clocks with chip-enable low
        ce = 1'b0; sdi = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); sclk = 1'b1; @(negedge clk); sclk = 1'b0;
            @(negedge clk);
            if (sdo !== 1'b0) begin checks++; failures++; $display("FAIL R12 sdo actual=%b expected=0", sdo); end
        end
        chk("R12", "sdo idle", {7'd0, sdo}, 8'h00);
        xfer(8'h02, 8'h00, rd); chk("R12", "state kept", rd, 8'h11);

        // R6 status clear key
        xfer(8'hB1, 8'hFB, rd);
        xfer(8'h30, 8'h00, rd); chk("R6", "no key no clear", rd, 8'h90);
        chk("R6", "irq kept", {7'd0, pwr_irq}, 8'h01);
        xfer(8'hB1, 8'h04, rd);
        xfer(8'h30, 8'h00, rd); chk("R6", "status cleared", rd, 8'h80);
        chk("R6", "irq cleared", {7'd0, pwr_irq}, 8'h00);
        xfer(8'h11, 8'h00, rd); chk("R3", "status write leaves ram", rd, 8'h00);

        // R9 R10 full rollover after ten ticks
        wait_cyc(21000);
        xfer(8'h20, 8'h00, rd); chk("R9", "sec roll", rd, 8'h00);
        xfer(8'h21, 8'h00, rd); chk("R9", "min roll", rd, 8'h00);
        xfer(8'h22, 8'h00, rd); chk("R9", "hour roll", rd, 8'h00);
        xfer(8'h24, 8'h00, rd); chk("R10", "day roll", rd, 8'h01);
        xfer(8'h25, 8'h00, rd); chk("R10", "month roll", rd, 8'h01);
        xfer(8'h26, 8'h00, rd); chk("R10", "year roll", rd, 8'h00);
        wait_cyc(23100);
        xfer(8'h20, 8'h00, rd); chk("R9", "one tick later", rd, 8'h01);

        // R5 R9 tick colliding with the read capture
        prev = rd;
        changed = 1'b0;
        for (int n = 0; n < 40; n++) begin
            xfer(8'h20, 8'h00, rd);
            if (rd != prev) begin
                chk("R5", "capture vs tick", rd, tb_bcd_next(prev));
                changed = 1'b1;
            end
            prev = rd;
        end
        chk("R9", "tick seen during reads", {7'd0, changed}, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule